// File: doc/BRIEF.md
# EEPROM End-of-Log Marker Scanner

This block locates the first free byte of a log held in a serial EEPROM. A log is closed by the three-byte marker 0xFD, 0xFD, 0xFE. After a start pulse the scanner opens a sequential read from address zero through a byte-level I2C master engine. It walks the memory one byte at a time and reports the address of the closing 0xFE. If no marker exists anywhere in the memory, it reports address zero. Bit timing on the wire is handled by the separate byte engine. This block only orders the byte-level operations and interprets the returned data.

The engine interface is a plain request/complete handshake. The scanner raises `bus_req_o` with an operation code and, for sends, a data byte. It holds all three steady until the engine pulses `bus_ack_i`. For a send, the engine reports on `bus_nack_i` whether the device failed to acknowledge. For a receive, it returns the byte on `bus_rdata_i`. Operation codes: 0 start, 1 repeated start, 2 stop, 3 send byte, 4 receive byte, 5 send master acknowledge.

Top module: `eeprom_marker_scan`

## Requirements
- R1: The search opens with a stop, a start and the write control byte 0xA6. While that control byte is not acknowledged, the stop, start and control byte are issued again.
- R2: Once the write control byte is acknowledged, the scanner sends two address bytes of 0x00 (high first), a repeated start and the read control byte 0xA7. All command fields stay stable while a request is pending.
- R3: Bytes are matched as a stream against 0xFD, 0xFD, 0xFE. On a complete match, `result_o` is the address of the 0xFE byte.
- R4: A byte that breaks a partial match is not re-tested as a new first 0xFD. So 0xFD, 0xFD, 0xFD, 0xFE contains no marker.
- R5: When every one of the 2^ADDR_W bytes has been read with no match, the result is 0.
- R6: Each non-final byte is followed by a master acknowledge and the next receive. The final byte (match or last address) is followed directly by a stop, with no acknowledge.
- R7: `done_o` is high for exactly one cycle at the end of a search, and `result_o` is valid in that cycle.
- R8: A start pulse that arrives while a search is in progress is ignored.
- R9: The partial-match state is cleared when a search ends. Leftover state from one search cannot complete a marker in the next.
- R10: After reset, `done_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse to begin a search |
| done_o | output | 1 | One-cycle end-of-search strobe |
| result_o | output | ADDR_W | First free address (0xFE position, or 0) |
| bus_req_o | output | 1 | Byte engine request pending |
| bus_op_o | output | 3 | Requested operation code |
| bus_wdata_o | output | 8 | Byte to send |
| bus_ack_i | input | 1 | Engine completed the request |
| bus_nack_i | input | 1 | Device did not acknowledge the sent byte |
| bus_rdata_i | input | 8 | Byte received by the engine |

## Verification
The bench targets several corners:
- A run of three 0xFD before 0xFE, which a matcher that re-tests the breaking byte would wrongly accept.
- A marker at address 0 and one ending on the very last address. An off-by-one counter would misreport these or finish early.
- A memory with no marker, which must yield 0 after exactly 2^ADDR_W reads.
- A memory ending in 0xFD, 0xFD followed by a search whose first byte is 0xFE. A design that keeps its match flags between searches would report 0 there.
- Refused control bytes, which a design without retry would push past with an unacknowledged device.
- A mid-search start pulse, which a careless design would use to restart and so issue extra stops.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_SEND    = 3'd3,
        OP_RECV    = 3'd4,
        OP_ACK     = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STOP_PRE,
        S_START,
        S_CTRL_WR,
        S_ADDR_HI,
        S_ADDR_LO,
        S_RESTART,
        S_CTRL_RD,
        S_RECV,
        S_EVAL,
        S_ACK,
        S_STOP_END
    } scan_state_e;

    typedef struct packed {
        logic    valid;
        bus_op_e op;
        logic [7:0] data;
    } bus_cmd_t;

    typedef struct packed {
        logic first_fd;
        logic second_fd;
    } match_flags_t;

    localparam logic [7:0] MARK_OPEN  = 8'hFD;
    localparam logic [7:0] MARK_CLOSE = 8'hFE;

    // Operation carried by each command-issuing state.
    function automatic bus_op_e state_op(scan_state_e s);
        case (s)
            S_START:                        return OP_START;
            S_RESTART:                      return OP_RESTART;
            S_CTRL_WR, S_ADDR_HI,
            S_ADDR_LO, S_CTRL_RD:           return OP_SEND;
            S_RECV:                         return OP_RECV;
            S_ACK:                          return OP_ACK;
            default:                        return OP_STOP;
        endcase
    endfunction

    // One step of the streaming matcher; a breaking byte clears the state
    // and is not tested again as a fresh opener.
    function automatic match_flags_t match_step(match_flags_t f, logic [7:0] b);
        match_flags_t n;
        n = f;
        if (!f.first_fd) begin
            n.first_fd = (b == MARK_OPEN);
        end else if (!f.second_fd) begin
            if (b == MARK_OPEN) n.second_fd = 1'b1;
            else                n = '0;
        end else begin
            if (b != MARK_CLOSE) n = '0;
        end
        return n;
    endfunction

endpackage

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr
    import mscan_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) addr_q <= '0;
        else if (inc)   addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
    assign last = (addr_q == TOP);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (addr_q == $past(addr_q) + 1'b1)) else $error("address step"); // R5

endmodule

// File: rtl/marker_matcher.sv
module marker_matcher
    import mscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  logic       eval,
    output logic       hit
);
    match_flags_t flags_q;
    logic [7:0]   byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
        end else if (load) begin
            byte_q <= byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags_q <= '0;
        end else if (eval) begin
            flags_q <= match_step(flags_q, byte_q);
        end
    end

    assign hit = eval && flags_q.first_fd && flags_q.second_fd && (byte_q == MARK_CLOSE);

    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        flags_q.second_fd |-> flags_q.first_fd) else $error("flag order"); // R4

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags_q == '0)) else $error("flags not cleared"); // R9

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import mscan_pkg::*;
#(
    parameter int         ADDR_W  = 15,
    parameter logic [7:0] CTRL_WR = 8'hA6,
    parameter logic [7:0] CTRL_RD = 8'hA7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bus_ack,
    input  logic              bus_nack,
    input  logic              hit,
    input  logic              last,
    input  logic [ADDR_W-1:0] addr,
    output bus_cmd_t          cmd,
    output logic              load,
    output logic              eval,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              flag_clr,
    output logic              done,
    output logic [ADDR_W-1:0] result
);
    scan_state_e       state_q, state_d;
    logic              done_q;
    logic [ADDR_W-1:0] result_q;

    always_comb begin
        cmd.valid = (state_q != S_IDLE) && (state_q != S_EVAL);
        cmd.op    = state_op(state_q);
        case (state_q)
            S_CTRL_WR: cmd.data = CTRL_WR;
            S_CTRL_RD: cmd.data = CTRL_RD;
            default:   cmd.data = 8'h00;
        endcase
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        eval     = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        flag_clr = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_STOP_PRE;
                    cnt_clr  = 1'b1;
                    flag_clr = 1'b1;
                end
            end
            S_STOP_PRE: if (bus_ack) state_d = S_START;
            S_START:    if (bus_ack) state_d = S_CTRL_WR;
            S_CTRL_WR:  if (bus_ack) state_d = bus_nack ? S_STOP_PRE : S_ADDR_HI;
            S_ADDR_HI:  if (bus_ack) state_d = S_ADDR_LO;
            S_ADDR_LO:  if (bus_ack) state_d = S_RESTART;
            S_RESTART:  if (bus_ack) state_d = S_CTRL_RD;
            S_CTRL_RD:  if (bus_ack) state_d = S_RECV;
            S_RECV: begin
                if (bus_ack) begin
                    load    = 1'b1;
                    state_d = S_EVAL;
                end
            end
            S_EVAL: begin
                eval = 1'b1;
                if (hit) begin
                    state_d = S_STOP_END;
                end else begin
                    cnt_inc = 1'b1;
                    state_d = last ? S_STOP_END : S_ACK;
                end
            end
            S_ACK:      if (bus_ack) state_d = S_RECV;
            S_STOP_END: begin
                if (bus_ack) begin
                    flag_clr = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_STOP_END) && bus_ack;
            if (state_q == S_EVAL) begin
                if (hit)       result_q <= addr;
                else if (last) result_q <= '0;
            end
        end
    end

    assign done   = done_q;
    assign result = result_q;

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && !bus_ack) |=> (cmd.valid && $stable(cmd.op) && $stable(cmd.data)))
        else $error("command changed while pending"); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R7

    AST_EVAL_AFTER_RECV: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EVAL) |-> ($past(state_q) == S_RECV)) else $error("eval without byte"); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == S_IDLE)) else $error("done while busy"); // R8

endmodule

// File: rtl/eeprom_marker_scan.sv
module eeprom_marker_scan
    import mscan_pkg::*;
#(
    parameter int         ADDR_W  = 15,
    parameter logic [7:0] CTRL_WR = 8'hA6,
    parameter logic [7:0] CTRL_RD = 8'hA7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] result_o,
    output logic              bus_req_o,
    output logic [2:0]        bus_op_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic              bus_nack_i,
    input  logic [7:0]        bus_rdata_i
);
    bus_cmd_t          cmd;
    logic              load, eval, cnt_clr, cnt_inc, flag_clr;
    logic              hit, last;
    logic [ADDR_W-1:0] addr;

    scan_seq #(
        .ADDR_W (ADDR_W),
        .CTRL_WR(CTRL_WR),
        .CTRL_RD(CTRL_RD)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .bus_ack (bus_ack_i),
        .bus_nack(bus_nack_i),
        .hit     (hit),
        .last    (last),
        .addr    (addr),
        .cmd     (cmd),
        .load    (load),
        .eval    (eval),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .flag_clr(flag_clr),
        .done    (done_o),
        .result  (result_o)
    );

    scan_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .addr(addr),
        .last(last)
    );

    marker_matcher u_match (
        .clk    (clk),
        .rst    (rst),
        .clr    (flag_clr),
        .load   (load),
        .byte_in(bus_rdata_i),
        .eval   (eval),
        .hit    (hit)
    );

    assign bus_req_o   = cmd.valid;
    assign bus_op_o    = cmd.op;
    assign bus_wdata_o = cmd.data;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && !bus_req_o)) else $error("not quiet after reset"); // R10

endmodule

// File: tb/tb_eeprom_marker_scan.sv
module tb_eeprom_marker_scan;
    import mscan_pkg::*;

    localparam int AW  = 10;
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          done_o;
    logic [AW-1:0] result_o;
    logic          bus_req_o;
    logic [2:0]    bus_op_o;
    logic [7:0]    bus_wdata_o;
    logic          bus_ack_i = 1'b0;
    logic          bus_nack_i = 1'b0;
    logic [7:0]    bus_rdata_i = 8'h00;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eeprom_marker_scan #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o), .result_o(result_o),
        .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .bus_wdata_o(bus_wdata_o),
        .bus_ack_i(bus_ack_i), .bus_nack_i(bus_nack_i), .bus_rdata_i(bus_rdata_i)
    );

    // Byte engine and device model
    logic [7:0] mem [0:MEM-1];
    int  nack_left, ctrl_wr_seen, ctrl_rd_seen, stops, reads, acks, addr_bytes;
    int  addr_nonzero, seq_bad, stop_after_recv;
    logic expect_ctrl;
    int  ptr, sends_after_ctrl;
    logic [2:0] prev_op;

    always @(negedge clk) begin
        if (bus_ack_i) begin
            bus_ack_i  = 1'b0;
            bus_nack_i = 1'b0;
        end else if (bus_req_o) begin
            case (bus_op_o)
                3'd0, 3'd1: begin
                    expect_ctrl = 1'b1;
                end
                3'd2: begin
                    stops++;
                    if (prev_op == 3'd4) stop_after_recv++;
                end
                3'd3: begin
                    if (expect_ctrl) begin
                        expect_ctrl = 1'b0;
                        sends_after_ctrl = 0;
                        if (bus_wdata_o == 8'hA6) begin
                            ctrl_wr_seen++;
                            if (prev_op != 3'd0) seq_bad++;
                            if (nack_left > 0) begin
                                nack_left--;
                                bus_nack_i = 1'b1;
                            end
                        end else if (bus_wdata_o == 8'hA7) begin
                            ctrl_rd_seen++;
                            if (prev_op != 3'd1 || addr_bytes != 2) seq_bad++;
                        end else seq_bad++;
                    end else begin
                        addr_bytes++;
                        if (bus_wdata_o != 8'h00) addr_nonzero++;
                        ptr = 0;
                    end
                end
                3'd4: begin
                    bus_rdata_i = mem[ptr % MEM];
                    ptr++;
                    reads++;
                end
                3'd5: acks++;
                default: seq_bad++;
            endcase
            prev_op   = bus_op_o;
            bus_ack_i = 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < MEM; i++) mem[i] = v;
    endtask

    task automatic put_marker(input int a);
        mem[a] = 8'hFD; mem[a+1] = 8'hFD; mem[a+2] = 8'hFE;
    endtask

    int done_width;
    int got_result;

    // Start one search, optionally poke start again mid-run, wait for done.
    task automatic run_scan(input int poke_at);
        int cyc;
        nack_left = nack_left;
        ctrl_wr_seen = 0; ctrl_rd_seen = 0; stops = 0; reads = 0; acks = 0;
        addr_bytes = 0; addr_nonzero = 0; seq_bad = 0; stop_after_recv = 0;
        expect_ctrl = 1'b0; ptr = 0; prev_op = 3'd7;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        got_result = int'(result_o);
        done_width = 0;
        while (done_o) begin
            done_width++;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 done low after reset", int'(done_o), 0);
        check("R10 no request after reset", int'(bus_req_o), 0);
    endtask

    task automatic t_basic;
        fill(8'h11); put_marker(10); nack_left = 0;
        run_scan(0);
        check("R3 result at 0xFE", got_result, 12);
        check("R6 bytes read", reads, 13);
        check("R6 acks between bytes", acks, 12);
        check("R6 stop follows final byte", stop_after_recv, 1);
        check("R2 two zero address bytes", addr_bytes, 2);
        check("R2 address value", addr_nonzero, 0);
        check("R2 control order", seq_bad, 0);
        check("R2 read control sent", ctrl_rd_seen, 1);
        check("R7 done width", done_width, 1);
    endtask

    task automatic t_at_zero;
        fill(8'h00); put_marker(0); nack_left = 0;
        run_scan(0);
        check("R3 marker at address 0", got_result, 2);
        check("R6 reads for marker at 0", reads, 3);
    endtask

    task automatic t_no_recheck;
        fill(8'h22);
        mem[20] = 8'hFD; mem[21] = 8'hFD; mem[22] = 8'hFD; mem[23] = 8'hFE;
        mem[40] = 8'hFD; mem[41] = 8'h33; mem[42] = 8'hFD; mem[43] = 8'hFE;
        put_marker(100);
        nack_left = 0;
        run_scan(0);
        check("R4 breaking byte not re-tested", got_result, 102);
        check("R4 reads up to real marker", reads, 103);
    endtask

    task automatic t_at_end;
        fill(8'h44); put_marker(MEM - 3); nack_left = 0;
        run_scan(0);
        check("R3 marker closing on last address", got_result, MEM - 1);
        check("R3 reads whole memory", reads, MEM);
    endtask

    task automatic t_absent_then_stale;
        fill(8'h55); mem[MEM-2] = 8'hFD; mem[MEM-1] = 8'hFD; nack_left = 0;
        run_scan(0);
        check("R5 absent marker gives 0", got_result, 0);
        check("R5 reads all bytes", reads, MEM);
        check("R6 no ack after last byte", acks, MEM - 1);
        check("R7 done width absent", done_width, 1);
        fill(8'h55); mem[0] = 8'hFE; put_marker(50);
        run_scan(0);
        check("R9 stale flags ignored", got_result, 52);
    endtask

    task automatic t_retry;
        fill(8'h66); put_marker(7); nack_left = 2;
        run_scan(0);
        check("R1 write control attempts", ctrl_wr_seen, 3);
        check("R1 stops incl. retries", stops, 4);
        check("R1 result after retries", got_result, 9);
        check("R1 control order", seq_bad, 0);
    endtask

    task automatic t_busy_start;
        fill(8'h77); put_marker(200); nack_left = 0;
        run_scan(300);
        check("R8 result with mid-run start", got_result, 202);
        check("R8 single opening", ctrl_wr_seen, 1);
        check("R8 stops", stops, 2);
        check("R8 reads", reads, 203);
        check("R8 no second done", int'(done_o), 0);
    endtask

    initial begin
        nack_left = 0;
        fill(8'h00);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_at_zero();
        t_no_recheck();
        t_at_end();
        t_absent_then_stale();
        t_retry();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule